// File: doc/BRIEF.md
# Machine-Mode Trap Control Unit

This block holds the machine-level trap state of a 64-bit core and sequences trap entry and trap return. When the pipeline raises a trap request (a synchronous exception or an accepted interrupt), the unit records the PC and trap value, writes the cause register, pushes the interrupt-enable bit onto its one-deep stack, and returns in the same cycle the address the fetch unit must jump to. That address comes from the trap-vector register.

A trap-return request pops the enable stack and returns the saved exception PC as the redirect target. A single CSR port reads and writes the trap registers at their usual architectural addresses, with the defined bits only. When a trap or a return is handled in a cycle, a CSR write in that same cycle is dropped.

Top module: `mtrap_ctl`

## Requirements
- R1: After reset every CSR reads 0, `redir_valid` is 0 and `tvec_err` is 0.
- R2: On trap entry, mcause (0x342) bit 63 takes `trap_is_irq` and bits 62..0 take `trap_code` zero-extended.
- R3: With trap-vector mode 0 (mtvec 0x305, bits 1..0 = 0), a trap redirects in the request cycle to base = {mtvec[63:2], 2'b00}.
- R4: With mode 1, an interrupt redirects to base + 4*`trap_code` and an exception redirects to base.
- R5: With mode 2 or 3, a trap raises `tvec_err` and leaves `redir_valid` at 0 in that cycle.
- R6: On trap entry, mepc (0x341) takes `trap_pc`, MPIE (mstatus 0x300 bit 7) takes the old MIE (bit 3), and MIE clears. mtval (0x343) takes `trap_val` for an exception and 0 for an interrupt.
- R7: On MRET, `redir_valid` is 1 and `redir_pc` is mepc with bit 0 cleared, in the request cycle. At the edge MIE takes MPIE and MPIE becomes 1.
- R8: When a trap and an MRET are requested in the same cycle, only the trap is handled: its target is output and its CSR updates are made.
- R9: Writes are masked. mip (0x344), mie (0x304) and mideleg (0x303) keep bits 11,9,8,7,5,4,3,1,0 (mask 0xBBB). medeleg (0x302) keeps bits 0..10, 12, 13 and 15 (mask 0xB7FF). mstatus keeps bits 3 and 7 only. mscratch (0x340), mepc, mcause, mtval and mtvec keep all 64 bits. Any other address reads 0.
- R10: A CSR write made in the same cycle as a trap or an MRET has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_code | input | CODE_W | Exception code or interrupt bit index |
| trap_pc | input | XLEN | PC to save in mepc |
| trap_val | input | XLEN | Value to save in mtval on exceptions |
| mret_req | input | 1 | Return from trap this cycle |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, combinational |
| redir_valid | output | 1 | `redir_pc` is a valid fetch target |
| redir_pc | output | XLEN | Redirect target |
| tvec_err | output | 1 | Trap taken while mtvec holds a reserved mode |

## Verification
The hardest case to reach is a collision at one clock edge: a trap arriving together with an MRET, or a CSR write arriving together with a trap. Both depend on ordering that normal traffic rarely produces. The bench drives these collisions directly from one task each. It then reads back mepc, mstatus and mscratch to show which request won. The vectored offset is exercised with a nonzero interrupt code. The same vector setting is then used with an exception, to show that exceptions get no offset.

// File: rtl/mtrap_ctl.sv
module mtrap_ctl #(
  parameter int XLEN   = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_val,
  input  logic              mret_req,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              tvec_err
);
  localparam logic [11:0] A_STATUS = 12'h300, A_EDELEG = 12'h302, A_IDELEG = 12'h303,
                          A_IE = 12'h304, A_TVEC = 12'h305, A_SCRATCH = 12'h340,
                          A_EPC = 12'h341, A_CAUSE = 12'h342, A_TVAL = 12'h343, A_IP = 12'h344;
  localparam logic [15:0] IRQ_MASK = 16'h0BBB;
  localparam logic [15:0] EXC_MASK = 16'hB7FF;

  logic            st_mie, st_mpie;
  logic [XLEN-1:0] r_epc, r_cause, r_tvec, r_tval, r_scratch;
  logic [15:0]     r_ip, r_ie, r_ideleg, r_edeleg;

  wire             do_trap = trap_req;
  wire             do_ret  = mret_req & ~trap_req;
  wire             wr_ok   = csr_we & ~trap_req & ~mret_req;
  wire [XLEN-1:0]  base    = {r_tvec[XLEN-1:2], 2'b00};
  wire [XLEN-1:0]  code_x  = XLEN'(trap_code);
  wire [XLEN-1:0]  vec_pc  = (r_tvec[1:0] == 2'b01 && trap_is_irq) ? base + (code_x << 2) : base;

  assign tvec_err    = do_trap & r_tvec[1];
  assign redir_valid = (do_trap & ~r_tvec[1]) | do_ret;
  assign redir_pc    = do_trap ? vec_pc : {r_epc[XLEN-1:1], 1'b0};

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_STATUS:  begin csr_rdata[3] = st_mie; csr_rdata[7] = st_mpie; end
      A_EDELEG:  csr_rdata = XLEN'(r_edeleg);
      A_IDELEG:  csr_rdata = XLEN'(r_ideleg);
      A_IE:      csr_rdata = XLEN'(r_ie);
      A_IP:      csr_rdata = XLEN'(r_ip);
      A_TVEC:    csr_rdata = r_tvec;
      A_SCRATCH: csr_rdata = r_scratch;
      A_EPC:     csr_rdata = r_epc;
      A_CAUSE:   csr_rdata = r_cause;
      A_TVAL:    csr_rdata = r_tval;
      default:   csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_mie <= 1'b0; st_mpie <= 1'b0;
      r_epc <= '0; r_cause <= '0; r_tvec <= '0; r_tval <= '0; r_scratch <= '0;
      r_ip <= '0; r_ie <= '0; r_ideleg <= '0; r_edeleg <= '0;
    end else if (do_trap) begin
      r_epc   <= trap_pc;
      r_cause <= {trap_is_irq, code_x[XLEN-2:0]};
      r_tval  <= trap_is_irq ? '0 : trap_val;
      st_mpie <= st_mie;
      st_mie  <= 1'b0;
    end else if (do_ret) begin
      st_mie  <= st_mpie;
      st_mpie <= 1'b1;
    end else if (wr_ok) begin
      case (csr_addr)
        A_STATUS:  begin st_mie <= csr_wdata[3]; st_mpie <= csr_wdata[7]; end
        A_EDELEG:  r_edeleg  <= csr_wdata[15:0] & EXC_MASK;
        A_IDELEG:  r_ideleg  <= csr_wdata[15:0] & IRQ_MASK;
        A_IE:      r_ie      <= csr_wdata[15:0] & IRQ_MASK;
        A_IP:      r_ip      <= csr_wdata[15:0] & IRQ_MASK;
        A_TVEC:    r_tvec    <= csr_wdata;
        A_SCRATCH: r_scratch <= csr_wdata;
        A_EPC:     r_epc     <= csr_wdata;
        A_CAUSE:   r_cause   <= csr_wdata;
        A_TVAL:    r_tval    <= csr_wdata;
        default: ;
      endcase
    end
  end

  a_r2_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> r_cause[XLEN-1] == $past(trap_is_irq));
  a_r5_reserved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    tvec_err |-> !redir_valid);
  a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> r_epc == $past(trap_pc));
  a_r6_enable_push: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !st_mie && st_mpie == $past(st_mie));
  a_r7_enable_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req) |=> st_mpie && st_mie == $past(st_mpie));
  a_r10_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req || mret_req) |=> $stable(r_scratch));
endmodule

// File: tb/mtrap_ctl_tb_top.sv
module mtrap_ctl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        trap_req = 0, trap_is_irq = 0, mret_req = 0, csr_we = 0;
  logic [5:0]  trap_code = 0;
  logic [63:0] trap_pc = 0, trap_val = 0, csr_wdata = 0;
  logic [11:0] csr_addr = 0;
  logic [63:0] csr_rdata, redir_pc;
  logic        redir_valid, tvec_err;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  mtrap_ctl dut_i (.clk, .rst_n, .trap_req, .trap_is_irq, .trap_code, .trap_pc, .trap_val,
    .mret_req, .csr_we, .csr_addr, .csr_wdata, .csr_rdata, .redir_valid, .redir_pc, .tvec_err);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1 csr_we = 0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [63:0] exp);
    @(negedge clk); csr_addr = a; #2 chk(req, csr_rdata, exp);
  endtask

  task automatic trap(logic irq, logic [5:0] code, logic [63:0] pc, logic [63:0] val,
                      string req, logic exp_v, logic [63:0] exp_pc, logic exp_err);
    @(negedge clk); trap_req = 1; trap_is_irq = irq; trap_code = code; trap_pc = pc; trap_val = val;
    #5;
    chk({req, " valid"}, 64'(redir_valid), 64'(exp_v));
    chk({req, " err"}, 64'(tvec_err), 64'(exp_err));
    if (exp_v) chk({req, " target"}, redir_pc, exp_pc);
    @(posedge clk); #1 trap_req = 0;
  endtask

  task automatic t_reset;
    foreach (addr_list[i]) rd("R1 reset csr", addr_list[i], 64'h0);
    chk("R1 reset valid", 64'(redir_valid), 64'h0);
    chk("R1 reset err", 64'(tvec_err), 64'h0);
  endtask

  logic [11:0] addr_list [10] = '{12'h300, 12'h302, 12'h303, 12'h304, 12'h305,
                                  12'h340, 12'h341, 12'h342, 12'h343, 12'h344};

  task automatic t_direct;
    wr(12'h305, 64'h8000_0100);
    wr(12'h300, 64'h8);
    trap(0, 6'd2, 64'h1000, 64'hDEAD, "R3 direct", 1, 64'h8000_0100, 0);
    rd("R6 mepc", 12'h341, 64'h1000);
    rd("R2 cause exc", 12'h342, 64'd2);
    rd("R6 mtval exc", 12'h343, 64'hDEAD);
    rd("R6 mstatus push", 12'h300, 64'h80);
  endtask

  task automatic t_vector;
    wr(12'h305, 64'h8000_0101);
    trap(1, 6'd7, 64'h2000, 64'hBEEF, "R4 vec irq", 1, 64'h8000_011C, 0);
    rd("R2 cause irq", 12'h342, 64'h8000_0000_0000_0007);
    rd("R6 mtval irq", 12'h343, 64'h0);
    rd("R6 mepc irq", 12'h341, 64'h2000);
    trap(0, 6'd3, 64'h2004, 64'h5, "R4 vec exc", 1, 64'h8000_0100, 0);
  endtask

  task automatic t_reserved;
    wr(12'h305, 64'h8000_0102);
    trap(0, 6'd2, 64'h3000, 64'h0, "R5 mode2", 0, 64'h0, 1);
    wr(12'h305, 64'h8000_0103);
    trap(1, 6'd11, 64'h3004, 64'h0, "R5 mode3", 0, 64'h0, 1);
  endtask

  task automatic do_mret(string req, logic [63:0] exp_pc);
    @(negedge clk); mret_req = 1; #5;
    chk({req, " valid"}, 64'(redir_valid), 64'h1);
    chk({req, " target"}, redir_pc, exp_pc);
    @(posedge clk); #1 mret_req = 0;
  endtask

  task automatic t_mret;
    wr(12'h300, 64'h80);
    wr(12'h341, 64'h4001);
    do_mret("R7 mret", 64'h4000);
    rd("R7 mstatus pop", 12'h300, 64'h88);
    wr(12'h300, 64'h08);
    do_mret("R7 mret2", 64'h4000);
    rd("R7 mstatus pop2", 12'h300, 64'h80);
  endtask

  task automatic t_priority;
    wr(12'h305, 64'h9000_0000);
    wr(12'h341, 64'h5000);
    wr(12'h300, 64'h08);
    @(negedge clk); trap_req = 1; mret_req = 1; trap_is_irq = 0; trap_code = 6'd8;
    trap_pc = 64'h6000; trap_val = 64'h0; #5;
    chk("R8 target", redir_pc, 64'h9000_0000);
    @(posedge clk); #1 trap_req = 0; mret_req = 0;
    rd("R8 mepc", 12'h341, 64'h6000);
    rd("R8 mstatus", 12'h300, 64'h80);
  endtask

  task automatic t_mask;
    wr(12'h304, '1);  rd("R9 mie", 12'h304, 64'hBBB);
    wr(12'h344, '1);  rd("R9 mip", 12'h344, 64'hBBB);
    wr(12'h303, '1);  rd("R9 mideleg", 12'h303, 64'hBBB);
    wr(12'h302, '1);  rd("R9 medeleg", 12'h302, 64'hB7FF);
    wr(12'h300, '1);  rd("R9 mstatus", 12'h300, 64'h88);
    wr(12'h340, '1);  rd("R9 mscratch", 12'h340, '1);
    wr(12'h7C0, '1);  rd("R9 unknown", 12'h7C0, 64'h0);
  endtask

  task automatic t_drop;
    wr(12'h340, 64'h1111);
    @(negedge clk); csr_we = 1; csr_addr = 12'h340; csr_wdata = 64'h2222;
    trap_req = 1; trap_is_irq = 0; trap_code = 6'd1; trap_pc = 64'h7000;
    @(posedge clk); #1 csr_we = 0; trap_req = 0;
    rd("R10 drop on trap", 12'h340, 64'h1111);
    @(negedge clk); csr_we = 1; csr_addr = 12'h340; csr_wdata = 64'h3333; mret_req = 1;
    @(posedge clk); #1 csr_we = 0; mret_req = 0;
    rd("R10 drop on mret", 12'h340, 64'h1111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_direct;
    t_vector;
    t_reserved;
    t_mret;
    t_priority;
    t_mask;
    t_drop;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule